// File: doc/BRIEF.md
# Key-Guarded Watchdog Timer with Early Warning

This peripheral is a watchdog for a processor subsystem. A 16-bit count runs down on ticks from a selectable prescaler. When the count drops below a chosen early-warning level, the block raises a warning flag and a one-cycle non-maskable interrupt request. If software does not service the watchdog in time, the count reaches zero. The block then raises an expiry flag and a one-cycle request to the system reset generator.

The configuration register is guarded against stray writes by a two-write key sequence. The first write to the configuration address must carry the arming key. The very next write to that address must carry the commit key, and it is the only write that changes the configuration. That same commit write reloads the count, clears both flags and restarts the prescaler, so software uses it as the keep-alive trigger.

Software reaches the block through a plain register bus with a write strobe, a read strobe, an address and 32-bit data.

Top module: `pwd_watchdog`

## Requirements
- R1: After a synchronous reset, the key sequence is locked and the watchdog is stopped. The count, the flags, the read data and both request outputs are zero, and a read of either register returns 0.
- R2: A configuration write (address 0x0) with 0xBE in bits 23:16 arms the key. The next configuration write applies its fields only if bits 23:16 hold 0xDC. The fields are: run enable in bit 31, warning select in bits 27:26, divider select in bits 25:24 and reload value in bits 15:0.
- R3: If the write that follows the arming write carries any other key byte, it is discarded and the key relocks. A write of 0xDC while the key is locked is ignored.
- R4: Divider codes 0, 1, 2 and 3 give one count tick every 1, 64, 4096 or 262144 clock cycles. Each commit restarts the prescaler, so the first tick comes that many cycles after the commit edge.
- R5: Warning codes 0, 1, 2 and 3 set the level to 0x8000, 0x4000, 0x2000 or 0x1000. The first tick that leaves the count below the level sets the warning flag and pulses `nmi_req` for exactly one cycle.
- R6: The tick that brings the count to zero sets the expiry flag and pulses `rst_req` for exactly one cycle. The count then stays at zero.
- R7: Every commit loads the count with the reload value and clears both flags. A commit issued before expiry therefore restarts the full timeout.
- R8: While the run enable is 0, the count does not change and no request is raised.
- R9: A read strobe returns data in the next cycle. Address 0x0 gives the configuration, with the fields in the positions of R2 and zeros in bits 23:16. Address 0x4 gives the status: the count in bits 15:0, the warning flag in bit 16, the run enable in bit 17 and the expiry flag in bit 18. Writes to address 0x4 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; it also drives the prescaler |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Register byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| nmi_req | output | 1 | One-cycle early-warning interrupt request |
| rst_req | output | 1 | One-cycle expiry reset request |

## Verification
The hardest case to reach from the ports is a keep-alive that lands while the count is already running, because its effect is visible only in when the warning request fires. The bench starts the count and waits a few cycles. It then runs a second full key sequence and expects `nmi_req` at a cycle measured from the second commit, not the first; a warning at the earlier time is an unexpected event. Reloads that already sit at or below the level, including a reload of 1 that makes both requests fire on the same tick, cover the boundaries of the threshold compare.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    localparam int CNT_W  = 16;
    localparam int PRE_W  = 18;
    localparam int DATA_W = 32;

    localparam logic [7:0] KEY_ARM    = 8'hBE;
    localparam logic [7:0] KEY_COMMIT = 8'hDC;

    typedef enum logic {
        KS_LOCKED,
        KS_ARMED
    } key_state_e;

    typedef struct packed {
        logic             run;
        logic [1:0]       warn_sel;
        logic [1:0]       div_sel;
        logic [CNT_W-1:0] reload;
    } wdg_cfg_t;

    typedef struct packed {
        logic             expired;
        logic             running;
        logic             warned;
        logic [CNT_W-1:0] count;
    } wdg_stat_t;

    // Early-warning level: half, quarter, eighth or sixteenth of the range.
    function automatic logic [CNT_W-1:0] warn_level(input logic [1:0] sel);
        return (CNT_W'(1) << (CNT_W - 1)) >> sel;
    endfunction

    // Last prescaler value before a tick: ratio 64**sel minus one.
    function automatic logic [PRE_W-1:0] div_last(input logic [1:0] sel);
        logic [PRE_W:0] ratio;
        ratio = (PRE_W+1)'(1) << (6 * sel);
        return PRE_W'(ratio - 1'b1);
    endfunction

    function automatic wdg_cfg_t cfg_from_word(input logic [DATA_W-1:0] w);
        wdg_cfg_t c;
        c.run      = w[31];
        c.warn_sel = w[27:26];
        c.div_sel  = w[25:24];
        c.reload   = w[CNT_W-1:0];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] cfg_to_word(input wdg_cfg_t c);
        logic [DATA_W-1:0] w;
        w          = '0;
        w[31]      = c.run;
        w[27:26]   = c.warn_sel;
        w[25:24]   = c.div_sel;
        w[CNT_W-1:0] = c.reload;
        return w;
    endfunction

endpackage

// File: rtl/wdg_keylock.sv
module wdg_keylock
    import wdg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_ctrl,
    input  logic [7:0] key,
    output logic       commit
);

    key_state_e state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= KS_LOCKED;
        end else if (wr_ctrl) begin
            unique case (state_q)
                KS_LOCKED: if (key == KEY_ARM) state_q <= KS_ARMED;
                KS_ARMED:  state_q <= KS_LOCKED;
                default:   state_q <= KS_LOCKED;
            endcase
        end
    end

    assign commit = wr_ctrl && (state_q == KS_ARMED) && (key == KEY_COMMIT);

    // R3: a commit always consumes the arming, so two cannot be adjacent
    p_no_double_commit_r3: assert property (@(posedge clk) disable iff (rst)
        commit |=> !commit);

    // R3: any control write seen while armed relocks the sequence
    p_relock_after_second_r3: assert property (@(posedge clk) disable iff (rst)
        (state_q == KS_ARMED && wr_ctrl) |=> (state_q == KS_LOCKED));

endmodule

// File: rtl/wdg_prescale.sv
module wdg_prescale
    import wdg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clear,
    input  logic       run,
    input  logic [1:0] div_sel,
    output logic       tick
);

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] last;

    assign last = div_last(div_sel);
    assign tick = run && (pre_q == last);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            pre_q <= '0;
        end else if (run) begin
            pre_q <= (pre_q == last) ? '0 : pre_q + 1'b1;
        end
    end

    // R4: with any divider above one, ticks are never back to back
    p_tick_spacing_r4: assert property (@(posedge clk) disable iff (rst)
        (tick && div_sel != 2'd0 && !clear) |=> !tick);

endmodule

// File: rtl/wdg_core.sv
module wdg_core
    import wdg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] reload,
    input  logic [1:0]       warn_sel,
    input  logic             run,
    input  logic             tick,
    output logic [CNT_W-1:0] count,
    output logic             warned,
    output logic             expired,
    output logic             nmi_pulse,
    output logic             rst_pulse
);

    logic [CNT_W-1:0] nxt;
    logic [CNT_W-1:0] level;

    assign nxt   = count - 1'b1;
    assign level = warn_level(warn_sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            count     <= '0;
            warned    <= 1'b0;
            expired   <= 1'b0;
            nmi_pulse <= 1'b0;
            rst_pulse <= 1'b0;
        end else begin
            nmi_pulse <= 1'b0;
            rst_pulse <= 1'b0;
            if (load) begin
                count   <= reload;
                warned  <= 1'b0;
                expired <= 1'b0;
            end else if (run && tick && count != '0) begin
                count <= nxt;
                if (nxt < level && !warned) begin
                    warned    <= 1'b1;
                    nmi_pulse <= 1'b1;
                end
                if (nxt == '0) begin
                    expired   <= 1'b1;
                    rst_pulse <= 1'b1;
                end
            end
        end
    end

    // R5: interrupt request lasts one cycle
    p_nmi_single_r5: assert property (@(posedge clk) disable iff (rst)
        nmi_pulse |=> !nmi_pulse);

    // R6: reset request lasts one cycle
    p_rst_single_r6: assert property (@(posedge clk) disable iff (rst)
        rst_pulse |=> !rst_pulse);

    // R6: an expired watchdog holds a zero count
    p_expired_at_zero_r6: assert property (@(posedge clk) disable iff (rst)
        expired |-> (count == '0));

    // R8: a stopped watchdog keeps its count
    p_hold_when_stopped_r8: assert property (@(posedge clk) disable iff (rst)
        (!run && !load) |=> $stable(count));

    // R4: without a load the count moves by at most one step
    p_single_step_r4: assert property (@(posedge clk) disable iff (rst)
        !load |=> (count == $past(count) || count == $past(count) - 1'b1));

endmodule

// File: rtl/pwd_watchdog.sv
module pwd_watchdog
    import wdg_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter logic [ADDR_W-1:0] CTRL_OFS = 4'h0,
    parameter logic [ADDR_W-1:0] STAT_OFS = 4'h4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              nmi_req,
    output logic              rst_req
);

    wdg_cfg_t         cfg_q;
    wdg_stat_t        stat;
    logic             wr_ctrl;
    logic             commit;
    logic             tick;
    logic [CNT_W-1:0] count;
    logic             warned;
    logic             expired;
    logic             unused_bits;

    assign wr_ctrl     = wr_en && (addr == CTRL_OFS);
    assign unused_bits = ^wdata[30:28];

    wdg_keylock u_keylock (
        .clk     (clk),
        .rst     (rst),
        .wr_ctrl (wr_ctrl),
        .key     (wdata[23:16]),
        .commit  (commit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (commit) begin
            cfg_q <= cfg_from_word(wdata);
        end
    end

    wdg_prescale u_prescale (
        .clk     (clk),
        .rst     (rst),
        .clear   (commit),
        .run     (cfg_q.run),
        .div_sel (cfg_q.div_sel),
        .tick    (tick)
    );

    wdg_core u_core (
        .clk       (clk),
        .rst       (rst),
        .load      (commit),
        .reload    (wdata[CNT_W-1:0]),
        .warn_sel  (cfg_q.warn_sel),
        .run       (cfg_q.run),
        .tick      (tick),
        .count     (count),
        .warned    (warned),
        .expired   (expired),
        .nmi_pulse (nmi_req),
        .rst_pulse (rst_req)
    );

    assign stat.expired = expired;
    assign stat.running = cfg_q.run;
    assign stat.warned  = warned;
    assign stat.count   = count;

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (rd_en) begin
            if (addr == CTRL_OFS)      rdata <= cfg_to_word(cfg_q);
            else if (addr == STAT_OFS) rdata <= 32'(stat);
            else                       rdata <= '0;
        end
    end

    // R1: nothing is requested during the cycle after reset
    p_quiet_after_reset_r1: assert property (@(posedge clk)
        $fell(rst) |-> (!nmi_req && !rst_req));

    // R8: a stopped watchdog never requests a reset
    p_no_reset_when_stopped_r8: assert property (@(posedge clk) disable iff (rst)
        (!cfg_q.run && !commit) |=> !rst_req);

endmodule

// File: tb/pwd_watchdog_bench.sv
module pwd_watchdog_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        nmi_req;
    logic        rst_req;

    int cyc = 0;
    int checks = 0;
    int fails = 0;
    int last_wr = 0;

    typedef struct {
        bit    is_rst;
        int    at;
        string req;
    } ev_t;
    ev_t evq[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pwd_watchdog u_pwd_watchdog (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .nmi_req(nmi_req), .rst_req(rst_req)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    // Monitor: pop the expected request events and compare cycle and kind
    task automatic pop_event(input bit is_rst);
        ev_t e;
        if (evq.size() == 0) begin
            check(1'b0, is_rst ? "R6" : "R5", "unexpected request", 32'(cyc), 32'hFFFF_FFFF);
        end else begin
            e = evq.pop_front();
            check(e.is_rst == is_rst && e.at == cyc, e.req,
                  is_rst ? "reset request cycle" : "nmi request cycle",
                  32'(cyc), 32'(e.at));
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (nmi_req) pop_event(1'b0);
            if (rst_req) pop_event(1'b1);
        end
    end

    task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        #1 last_wr = cyc;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    // Full key sequence; returns the cycle of the commit edge
    task automatic commit_cfg(input logic [31:0] word, output int at);
        bus_wr(4'h0, 32'h00BE_0000);
        bus_wr(4'h0, word | 32'h00DC_0000);
        at = last_wr;
    endtask

    task automatic expect_ev(input bit is_rst, input int at, input string req);
        ev_t e;
        e.is_rst = is_rst; e.at = at; e.req = req;
        evq.push_back(e);
    endtask

    task automatic drain(input int limit);
        for (int i = 0; i < limit && evq.size() != 0; i++) @(posedge clk);
        check(evq.size() == 0, "R5", "pending events drained", 32'(evq.size()), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog timeout actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        int c;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        check(nmi_req == 0 && rst_req == 0, "R1", "requests after reset",
              {nmi_req, rst_req}, 0);
        check(rdata == 0, "R1", "rdata after reset", rdata, 0);
        bus_rd(4'h4, rd); check(rd == 0, "R1", "status after reset", rd, 0);
        bus_rd(4'h0, rd); check(rd == 0, "R1", "config after reset", rd, 0);

        // R3 lone commit key while locked
        bus_wr(4'h0, 32'h8CDC_0100);
        repeat (5) @(posedge clk);
        bus_rd(4'h4, rd); check(rd == 0, "R3", "lone commit key ignored", rd, 0);

        // R3 wrong second key discards and relocks
        bus_wr(4'h0, 32'h00BE_0000);
        bus_wr(4'h0, 32'h8C00_0100);
        bus_wr(4'h0, 32'h8CDC_0100);
        repeat (5) @(posedge clk);
        bus_rd(4'h4, rd); check(rd == 0, "R3", "bad key relocks", rd, 0);

        // R2 R5 R6: div 1, level 0x1000, reload 0x1005
        commit_cfg(32'h8C00_1005, c);
        expect_ev(1'b0, c + 6, "R5");
        expect_ev(1'b1, c + 32'h1005, "R6");
        drain(6000);
        bus_rd(4'h4, rd); check(rd == 32'h0007_0000, "R6", "status after expiry", rd, 32'h0007_0000);
        bus_rd(4'h0, rd); check(rd == 32'h8C00_1005, "R9", "config readback", rd, 32'h8C00_1005);
        repeat (20) @(posedge clk);
        bus_rd(4'h4, rd); check(rd == 32'h0007_0000, "R6", "count held at zero", rd, 32'h0007_0000);

        // R7 keep-alive while running: warning counted from the second commit
        commit_cfg(32'h8C00_1010, c);
        repeat (8) @(posedge clk);
        commit_cfg(32'h8C00_1010, c);
        expect_ev(1'b0, c + 17, "R7");
        drain(100);

        // R8 stop, R7 flags cleared by commit
        commit_cfg(32'h0C00_1234, c);
        bus_rd(4'h4, rd); check(rd == 32'h0000_1234, "R7", "reload clears flags", rd, 32'h0000_1234);
        repeat (100) @(posedge clk);
        bus_rd(4'h4, rd); check(rd == 32'h0000_1234, "R8", "stopped count held", rd, 32'h0000_1234);

        // R9 writes to status are ignored
        bus_wr(4'h4, 32'hFFFF_FFFF);
        bus_rd(4'h4, rd); check(rd == 32'h0000_1234, "R9", "status write ignored", rd, 32'h0000_1234);

        // R4 divider 64, level 0x8000 (code 0), reload 0x8002: third tick warns
        commit_cfg(32'h8100_8002, c);
        expect_ev(1'b0, c + 3 * 64, "R4");
        drain(400);
        commit_cfg(32'h0000_0000, c);

        // R4 divider 4096, level 0x1000, reload 0x1002
        commit_cfg(32'h8E00_1002, c);
        expect_ev(1'b0, c + 3 * 4096, "R4");
        drain(13000);
        commit_cfg(32'h0000_0000, c);

        // R5 level 0x4000 (code 1), reload 0x4003, then expiry
        commit_cfg(32'h8400_4003, c);
        expect_ev(1'b0, c + 4, "R5");
        expect_ev(1'b1, c + 32'h4003, "R6");
        drain(17000);

        // R5 reload equal to level 0x2000 (code 2): first tick warns
        commit_cfg(32'h8800_2000, c);
        expect_ev(1'b0, c + 1, "R5");
        expect_ev(1'b1, c + 32'h2000, "R6");
        drain(9000);

        // R5 R6 reload of 1: both requests on the same tick
        commit_cfg(32'h8C00_0001, c);
        expect_ev(1'b0, c + 1, "R5");
        expect_ev(1'b1, c + 1, "R6");
        drain(50);
        bus_rd(4'h4, rd); check(rd == 32'h0007_0000, "R6", "status after short expiry", rd, 32'h0007_0000);

        repeat (10) @(posedge clk);
        check(evq.size() == 0, "R8", "no stray events", 32'(evq.size()), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule